// File: doc/BRIEF.md
# Floating-Point Load/Store Address Sequencer

This block sits between an instruction decoder and a word-wide memory port. It handles floating-point load and store instructions. For each request it computes the effective byte address. It checks that the address is aligned and that the register number is legal for the access size. It then issues one memory beat for a word access, or two beats for a doubleword access. Each beat carries the register-file index that the data belongs to. For loads, a write-back strobe marks each completed beat. For stores, the register file uses the index to supply the outgoing word.

A request is a single-cycle strobe on `req_valid`, sent with the instruction word and the two integer operand values. A request is only taken while the block is idle. When a check fails, the block raises a one-cycle fault pulse and makes no memory access.

Top module: `fp_mem_agu`

## Requirements
- R1: When instruction bit 13 is 1, the effective address is `rs1_val` plus bits 12:0, sign-extended to 32 bits.
- R2: When instruction bit 13 is 0, the effective address is `rs1_val + rs2_val`.
- R3: Bits 24:19 of the instruction select the operation:
  - 6'h20 is a word load.
  - 6'h23 is a doubleword load.
  - 6'h24 is a word store.
  - 6'h27 is a doubleword store.
  - Any other code gives an `fault_illegal` pulse and no memory access. This check takes priority over all other checks.
- R4: A doubleword access whose address has a non-zero value in bits 2:0 gives an `fault_align` pulse and no access. This check takes priority over the odd-register check.
- R5: A word access whose address has a non-zero value in bits 1:0 gives an `fault_align` pulse and no access.
- R6: A doubleword access that is aligned but names an odd register in instruction bits 29:25 gives an `fault_illegal` pulse and no access.
- R7: A doubleword load makes two beats in order:
  - a beat at ea with `reg_idx` = rd;
  - then a beat at ea+4 with `reg_idx` = rd+1.
  - `reg_wb` is high on each beat that completes.
- R8: A doubleword store makes the same two beats in the same order, with `mem_we` high and `reg_wb` never high.
- R9: A word access makes exactly one beat at ea with `reg_idx` = rd. Odd rd is allowed.
- R10: `busy` is high from the cycle after a request is taken until the last beat completes. Requests that arrive while busy have no effect.
- R11: A fault is a pulse lasting exactly one cycle, in the cycle after the request. During a fault, `busy`, `mem_valid` and `reg_wb` stay low.
- R12: While `mem_valid` is high and `mem_ready` is low, the address, write-enable and index hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First integer operand |
| rs2_val | input | 32 | Second integer operand |
| busy | output | 1 | Access in progress |
| mem_valid | output | 1 | Beat presented to memory |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_addr | output | 32 | Beat byte address |
| mem_we | output | 1 | Beat is a write |
| reg_idx | output | 5 | Register index for the beat |
| reg_wb | output | 1 | Load data write-back strobe |
| fault_align | output | 1 | Misalignment pulse |
| fault_illegal | output | 1 | Illegal instruction pulse |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Negative immediates.** Dropping the sign extension moves these accesses up by 8 KiB.
- **Doubleword addresses that are 4-aligned but not 8-aligned.** A design that only checks two address bits would issue a beat at these addresses.
- **A doubleword with both an odd register and a bad address.** This tests the fault priority: a swapped priority raises the wrong flag.
- **A word access with an odd register.** This must still proceed normally.
- **A stalled doubleword load that receives a second request while busy.** A design that lets the new request through would corrupt the held address. A design without the second beat, or with the pair out of order, would show the wrong address or index on the next beat.

// File: rtl/fp_mem_agu.sv
module fp_mem_agu #(
  parameter logic [5:0] OP_LDW = 6'h20,
  parameter logic [5:0] OP_LDD = 6'h23,
  parameter logic [5:0] OP_STW = 6'h24,
  parameter logic [5:0] OP_STD = 6'h27
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] instr,
  input  logic [31:0] rs1_val,
  input  logic [31:0] rs2_val,
  output logic        busy,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  output logic        mem_we,
  output logic [4:0]  reg_idx,
  output logic        reg_wb,
  output logic        fault_align,
  output logic        fault_illegal
);

  typedef enum logic [1:0] {S_IDLE, S_FIRST, S_SECOND} state_t;

  state_t      state;
  logic [31:0] ea_q;
  logic [4:0]  rd_q;
  logic        st_q, dw_q;

  wire [5:0]  op      = instr[24:19];
  wire [4:0]  rd      = instr[29:25];
  wire [31:0] imm     = {{19{instr[12]}}, instr[12:0]};
  wire [31:0] ea      = rs1_val + (instr[13] ? imm : rs2_val);
  wire        op_ok   = (op == OP_LDW) || (op == OP_LDD) || (op == OP_STW) || (op == OP_STD);
  wire        op_dw   = (op == OP_LDD) || (op == OP_STD);
  wire        op_st   = (op == OP_STW) || (op == OP_STD);
  wire        misal   = op_dw ? (ea[2:0] != 3'd0) : (ea[1:0] != 2'd0);
  wire        take    = req_valid && (state == S_IDLE);
  wire        second  = (state == S_SECOND);

  assign busy      = (state != S_IDLE);
  assign mem_valid = busy;
  assign mem_addr  = second ? ea_q + 32'd4 : ea_q;
  assign mem_we    = busy && st_q;
  assign reg_idx   = second ? (rd_q | 5'd1) : rd_q;
  assign reg_wb    = mem_valid && mem_ready && !st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      ea_q          <= '0;
      rd_q          <= '0;
      st_q          <= 1'b0;
      dw_q          <= 1'b0;
      fault_align   <= 1'b0;
      fault_illegal <= 1'b0;
    end else begin
      fault_align   <= 1'b0;
      fault_illegal <= 1'b0;
      case (state)
        S_IDLE: if (take) begin
          if (!op_ok)                fault_illegal <= 1'b1;
          else if (misal)            fault_align   <= 1'b1;
          else if (op_dw && rd[0])   fault_illegal <= 1'b1;
          else begin
            ea_q  <= ea;
            rd_q  <= rd;
            st_q  <= op_st;
            dw_q  <= op_dw;
            state <= S_FIRST;
          end
        end
        S_FIRST:  if (mem_ready) state <= dw_q ? S_SECOND : S_IDLE;
        S_SECOND: if (mem_ready) state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fp_mem_agu_chk.sv
module fp_mem_agu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic        mem_we,
  input logic [4:0]  reg_idx,
  input logic        reg_wb,
  input logic        fault_align,
  input logic        fault_illegal
);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(reg_idx));

  p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_align && fault_illegal));

  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_align || fault_illegal) |-> !mem_valid && !reg_wb && !busy);

  p_store_no_wb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !reg_wb);

  p_word_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  p_busy_span_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> busy);

endmodule

bind fp_mem_agu fp_mem_agu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_we(mem_we), .reg_idx(reg_idx), .reg_wb(reg_wb),
  .fault_align(fault_align), .fault_illegal(fault_illegal)
);

// File: tb/tb_fp_mem_agu.sv
module tb_fp_mem_agu;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, mem_ready = 1'b1;
  logic [31:0] instr = '0, rs1_val = '0, rs2_val = '0;
  logic busy, mem_valid, mem_we, reg_wb, fault_align, fault_illegal;
  logic [31:0] mem_addr;
  logic [4:0] reg_idx;
  int runs = 0, fails = 0;

  always #10 clk = ~clk;

  fp_mem_agu dut (.*);

  localparam int NV = 11;
  // kind: 0 word ok, 1 doubleword ok, 2 align fault, 3 illegal fault
  localparam logic [5:0]  T_OP   [NV] = '{6'h20, 6'h20, 6'h24, 6'h23, 6'h27, 6'h23, 6'h27, 6'h23, 6'h20, 6'h21, 6'h24};
  localparam logic [4:0]  T_RD   [NV] = '{5, 5, 7, 4, 10, 2, 3, 3, 1, 0, 9};
  localparam logic        T_ISEL [NV] = '{1, 1, 0, 0, 1, 1, 1, 1, 1, 1, 0};
  localparam logic [12:0] T_IMM  [NV] = '{13'd8, 13'h1FFC, 13'd0, 13'd0, 13'h1FF0, 13'd4, 13'd0, 13'd2, 13'd2, 13'd0, 13'd0};
  localparam logic [31:0] T_RS1  [NV] = '{32'h1000, 32'h2000, 32'h100, 32'h3000, 32'h4000, 32'h5000, 32'h6000, 32'h6000, 32'h8000, 32'h0, 32'h10};
  localparam logic [31:0] T_RS2  [NV] = '{32'h0, 32'h0, 32'h24, 32'h8, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h10};
  localparam logic [31:0] T_EA   [NV] = '{32'h1008, 32'h1FFC, 32'h124, 32'h3008, 32'h3FF0, 32'h5004, 32'h6000, 32'h6002, 32'h8002, 32'h0, 32'h20};
  localparam int          T_KIND [NV] = '{0, 0, 0, 1, 1, 2, 3, 2, 2, 3, 0};
  localparam string       T_REQ  [NV] = '{"R1", "R1", "R2", "R7", "R8", "R4", "R6", "R4", "R5", "R3", "R9"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [5:0] op, input logic [4:0] rd, input logic isel,
                       input logic [12:0] imm, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    instr = {2'b11, rd, op, 5'd1, isel, imm};
    rs1_val = a; rs2_val = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset busy", busy, 0);
    check("R11 reset faults", {fault_align, fault_illegal, mem_valid}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(T_OP[i], T_RD[i], T_ISEL[i], T_IMM[i], T_RS1[i], T_RS2[i]);
      if (T_KIND[i] >= 2) begin
        check(T_REQ[i], fault_align, T_KIND[i] == 2);
        check(T_REQ[i], fault_illegal, T_KIND[i] == 3);
        check("R11 no access", {mem_valid, busy, reg_wb}, 0);
        @(negedge clk);
        check("R11 pulse", {fault_align, fault_illegal}, 0);
      end else begin
        logic st;
        st = (T_OP[i] == 6'h24) || (T_OP[i] == 6'h27);
        check(T_REQ[i], mem_addr, T_EA[i]);
        check(T_REQ[i], {mem_valid, busy, mem_we}, {2'b11, st});
        check(T_REQ[i], reg_idx, T_RD[i]);
        check(T_REQ[i], reg_wb, !st);
        if (T_KIND[i] == 1) begin
          @(negedge clk);
          check(T_REQ[i], mem_addr, T_EA[i] + 4);
          check(T_REQ[i], reg_idx, T_RD[i] + 1);
          check(T_REQ[i], {mem_valid, mem_we, reg_wb}, {1'b1, st, !st});
        end
        @(negedge clk);
        check("R10 idle after last beat", {busy, mem_valid}, 0);
      end
    end

    // stall + ignored request while busy
    mem_ready = 1'b0;
    issue(6'h23, 5'd2, 1'b1, 13'd0, 32'h7000, 32'h0);
    check("R10 busy", busy, 1);
    check("R12 addr", mem_addr, 32'h7000);
    check("R12 no wb stalled", reg_wb, 0);
    issue(6'h24, 5'd6, 1'b1, 13'd0, 32'h9000, 32'h0);
    check("R10 ignored addr", mem_addr, 32'h7000);
    check("R10 ignored we", mem_we, 0);
    check("R12 idx", reg_idx, 5'd2);
    mem_ready = 1'b1;
    #1;
    check("R7 wb first", reg_wb, 1);
    @(negedge clk);
    check("R7 second addr", mem_addr, 32'h7004);
    check("R7 second idx", reg_idx, 5'd3);
    check("R10 busy last beat", busy, 1);
    @(negedge clk);
    check("R10 idle", busy, 0);
    @(negedge clk);
    check("R10 no late start", mem_valid, 0);

    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule